// File: doc/BRIEF.md
# Store Vector Load Scheduler

This block decides when each in-flight load may issue. It does not compare addresses. It tracks dependences on stores by relative age. A prediction table is indexed by the load PC. Each table entry is a bit vector with one bit per fetch-order distance to an older store. When a load is decoded, its entry is read out. The vector is turned into absolute store-queue columns and written into that load's row of a scheduling matrix. The matrix has one row per load slot and one column per store-queue slot.

A store that issues clears its column in every row in the same cycle. A load is ready once its row holds no set bits. When a memory-order violation is reported, the table learns the distance between the load and the offending store. A clear pulse wipes the whole table, so that stale dependences are forgotten. Stores that a load waits on may issue in any order, and one store may hold back any number of loads. Address checks and replay are left to the surrounding pipeline.

Top module: `store_vec_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every bit of `ld_ready` is 0.
- R2: A decode writes the table entry selected by `dec_pc` into the row of `dec_slot`. The entry index is `dec_pc[PC_LSB +: log2(SVT_ENTRIES)]`, where PC_LSB is 2. On the next cycle the load's ready bit is 1 if the written row is empty, and 0 otherwise.
- R3: Vector bit k stands for the store at fetch-order distance k+1 from the load. Bit k maps to column `(dec_young_idx - k) mod SQ_DEPTH`, which wraps below column 0.
- R4: A store issue in column j clears column j in every row from the next cycle on. A load's ready bit rises once its last set bit is cleared.
- R5: A violation sets bit `viol_dist` of the entry indexed by `viol_pc`. Later decodes with that PC see the bit. Rows that were already written do not change.
- R6: Vector bits with k >= `dec_older_cnt` are dropped when the row is written.
- R7: A store that issues in the same cycle as a decode has its column removed from the incoming row.
- R8: `ld_done` frees the row of `ld_done_slot`. That slot's ready bit is 0 from the next cycle until it is decoded again.
- R9: `tbl_clear` zeroes every table entry. Loads decoded afterwards are ready at once. Rows already written are not changed by the clear.
- R10: Predicted stores may issue in any order. A single store column may hold back several loads, and all of them are released together when that store issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_vld | input | 1 | Load decode strobe |
| dec_pc | input | PC_W | PC of the decoded load |
| dec_slot | input | log2(LQ_DEPTH) | Matrix row given to the load |
| dec_young_idx | input | log2(SQ_DEPTH) | Store-queue index of the youngest store older than the load |
| dec_older_cnt | input | log2(SQ_DEPTH+1) | Number of valid stores older than the load |
| st_vld | input | 1 | Store issue strobe |
| st_slot | input | log2(SQ_DEPTH) | Store-queue index of the issuing store |
| viol_vld | input | 1 | Violation report strobe |
| viol_pc | input | PC_W | PC of the violating load |
| viol_dist | input | log2(SQ_DEPTH) | Distance code k (distance k+1) |
| ld_done | input | 1 | Load issued or squashed, free its row |
| ld_done_slot | input | log2(LQ_DEPTH) | Row to free |
| tbl_clear | input | 1 | Clear every table entry |
| ld_ready | output | LQ_DEPTH | Per-row ready bit |

## Verification
Every result in this block is due exactly one clock edge after the stimulus that causes it. Decode, store issue and free each update the registered rows at that edge, and `ld_ready` is decoded from the rows without further delay. A violation or a clear changes the table at one edge, so a decode can see the change from the following cycle. The bench drives each stimulus for one cycle from the falling edge and samples `ld_ready` at the next falling edge. Training and decode are kept in separate cycles, so each check lands on the cycle in which its result first appears.

// File: rtl/svls_pkg.sv
// Shared defaults for the store vector load scheduler.
// Assumes the store-queue depth is a power of two so column arithmetic wraps naturally.
package svls_pkg;
    localparam int SVLS_SQ_DEPTH    = 32;
    localparam int SVLS_LQ_DEPTH    = 16;
    localparam int SVLS_SVT_ENTRIES = 64;
    localparam int SVLS_PC_W        = 32;
    localparam int SVLS_PC_LSB      = 2;
endpackage

// File: rtl/svls_vec_table.sv
// Prediction table: one store-distance vector per PC index.
// Training sets a single bit; a clear pulse zeroes the whole table and wins over training.
// Reads are combinational, so a write becomes visible to reads on the next cycle.
module svls_vec_table #(
    parameter int SQ_DEPTH = svls_pkg::SVLS_SQ_DEPTH,
    parameter int ENTRIES  = svls_pkg::SVLS_SVT_ENTRIES,
    parameter int PC_W     = svls_pkg::SVLS_PC_W,
    parameter int PC_LSB   = svls_pkg::SVLS_PC_LSB,
    localparam int SQ_IW   = $clog2(SQ_DEPTH),
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                trn_vld,
    input  logic [PC_W-1:0]     trn_pc,
    input  logic [SQ_IW-1:0]    trn_k,
    input  logic [PC_W-1:0]     rd_pc,
    output logic [SQ_DEPTH-1:0] rd_vec
);
    logic [SQ_DEPTH-1:0] tbl_q [ENTRIES];
    logic [IDX_W-1:0]    trn_idx;
    logic [IDX_W-1:0]    rd_idx;
    logic                tbl_any;

    assign trn_idx = trn_pc[PC_LSB +: IDX_W];
    assign rd_idx  = rd_pc[PC_LSB +: IDX_W];
    assign rd_vec  = tbl_q[rd_idx];

    // Purpose: clear or train the table entries.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int e = 0; e < ENTRIES; e++) tbl_q[e] <= '0;
        end else if (trn_vld) begin
            tbl_q[trn_idx][trn_k] <= 1'b1;
        end
    end

    // Purpose: summary of table occupancy for the checks below.
    always_comb begin
        tbl_any = 1'b0;
        for (int e = 0; e < ENTRIES; e++) tbl_any = tbl_any | (|tbl_q[e]);
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tbl_any); // R9
    AST_TRAIN_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_vld && !clr) |=> tbl_q[$past(trn_idx)][$past(trn_k)]); // R5
endmodule

// File: rtl/svls_col_map.sv
// Turns a relative-distance vector into absolute store-queue columns.
// Bit k (distance k+1) maps to column young-k mod depth; bits at or beyond the
// count of valid older stores are dropped. Purely combinational.
module svls_col_map #(
    parameter int SQ_DEPTH = svls_pkg::SVLS_SQ_DEPTH,
    localparam int SQ_IW   = $clog2(SQ_DEPTH),
    localparam int CNT_W   = $clog2(SQ_DEPTH + 1)
) (
    input  logic [SQ_DEPTH-1:0] rel_vec,
    input  logic [SQ_IW-1:0]    young_idx,
    input  logic [CNT_W-1:0]    older_cnt,
    output logic [SQ_DEPTH-1:0] abs_cols
);
    for (genvar c = 0; c < SQ_DEPTH; c++) begin : g_col
        localparam logic [SQ_IW-1:0] COL = SQ_IW'(c);
        logic [SQ_IW-1:0] dist_k;
        assign dist_k      = young_idx - COL;
        assign abs_cols[c] = rel_vec[dist_k] && (CNT_W'(dist_k) < older_cnt);
    end
endmodule

// File: rtl/svls_ld_matrix.sv
// Load scheduling matrix: one row per load slot, one column per store-queue slot.
// A decode writes a row, with any column issuing in the same cycle masked out. A store
// issue clears its column in all rows. A free empties a row; a decode to the same slot wins.
module svls_ld_matrix #(
    parameter int SQ_DEPTH = svls_pkg::SVLS_SQ_DEPTH,
    parameter int LQ_DEPTH = svls_pkg::SVLS_LQ_DEPTH,
    localparam int SQ_IW   = $clog2(SQ_DEPTH),
    localparam int LQ_IW   = $clog2(LQ_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_vld,
    input  logic [LQ_IW-1:0]    wr_slot,
    input  logic [SQ_DEPTH-1:0] wr_row,
    input  logic                st_vld,
    input  logic [SQ_IW-1:0]    st_slot,
    input  logic                fr_vld,
    input  logic [LQ_IW-1:0]    fr_slot,
    output logic [LQ_DEPTH-1:0] ready
);
    logic [SQ_DEPTH-1:0] row_q [LQ_DEPTH];
    logic [LQ_DEPTH-1:0] vld_q;
    logic [SQ_DEPTH-1:0] st_mask;
    logic [SQ_DEPTH-1:0] col_any;

    // Purpose: one-hot mask of the column being cleared this cycle.
    always_comb begin
        st_mask = '0;
        if (st_vld) st_mask[st_slot] = 1'b1;
    end

    for (genvar r = 0; r < LQ_DEPTH; r++) begin : g_row
        // Purpose: write, clear-column or free one matrix row.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[r] <= '0;
                vld_q[r] <= 1'b0;
            end else if (wr_vld && wr_slot == LQ_IW'(r)) begin
                row_q[r] <= wr_row & ~st_mask;
                vld_q[r] <= 1'b1;
            end else if (fr_vld && fr_slot == LQ_IW'(r)) begin
                row_q[r] <= '0;
                vld_q[r] <= 1'b0;
            end else begin
                row_q[r] <= row_q[r] & ~st_mask;
            end
        end
        assign ready[r] = vld_q[r] && !(|row_q[r]);
    end

    // Purpose: per-column occupancy across all rows, for the checks below.
    always_comb begin
        col_any = '0;
        for (int r = 0; r < LQ_DEPTH; r++) col_any = col_any | row_q[r];
    end

    AST_COLUMN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        st_vld |=> !col_any[$past(st_slot)]); // R4
    AST_FREE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_vld && !(wr_vld && wr_slot == fr_slot)) |=> !ready[$past(fr_slot)]); // R8
endmodule

// File: rtl/store_vec_sched.sv
// Top of the store vector load scheduler: prediction table, distance-to-column
// mapping and scheduling matrix. Assumes the caller supplies, at decode, the
// youngest older store index and the count of valid older stores.
module store_vec_sched #(
    parameter int SQ_DEPTH    = svls_pkg::SVLS_SQ_DEPTH,
    parameter int LQ_DEPTH    = svls_pkg::SVLS_LQ_DEPTH,
    parameter int SVT_ENTRIES = svls_pkg::SVLS_SVT_ENTRIES,
    parameter int PC_W        = svls_pkg::SVLS_PC_W,
    parameter int PC_LSB      = svls_pkg::SVLS_PC_LSB,
    localparam int SQ_IW      = $clog2(SQ_DEPTH),
    localparam int LQ_IW      = $clog2(LQ_DEPTH),
    localparam int CNT_W      = $clog2(SQ_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_vld,
    input  logic [PC_W-1:0]     dec_pc,
    input  logic [LQ_IW-1:0]    dec_slot,
    input  logic [SQ_IW-1:0]    dec_young_idx,
    input  logic [CNT_W-1:0]    dec_older_cnt,
    input  logic                st_vld,
    input  logic [SQ_IW-1:0]    st_slot,
    input  logic                viol_vld,
    input  logic [PC_W-1:0]     viol_pc,
    input  logic [SQ_IW-1:0]    viol_dist,
    input  logic                ld_done,
    input  logic [LQ_IW-1:0]    ld_done_slot,
    input  logic                tbl_clear,
    output logic [LQ_DEPTH-1:0] ld_ready
);
    logic [SQ_DEPTH-1:0] pred_vec;
    logic [SQ_DEPTH-1:0] mapped_row;

    svls_vec_table #(
        .SQ_DEPTH(SQ_DEPTH), .ENTRIES(SVT_ENTRIES), .PC_W(PC_W), .PC_LSB(PC_LSB)
    ) table_i (
        .clk(clk), .rst_n(rst_n), .clr(tbl_clear),
        .trn_vld(viol_vld), .trn_pc(viol_pc), .trn_k(viol_dist),
        .rd_pc(dec_pc), .rd_vec(pred_vec)
    );

    svls_col_map #(.SQ_DEPTH(SQ_DEPTH)) map_i (
        .rel_vec(pred_vec), .young_idx(dec_young_idx),
        .older_cnt(dec_older_cnt), .abs_cols(mapped_row)
    );

    svls_ld_matrix #(.SQ_DEPTH(SQ_DEPTH), .LQ_DEPTH(LQ_DEPTH)) matrix_i (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(dec_vld), .wr_slot(dec_slot), .wr_row(mapped_row),
        .st_vld(st_vld), .st_slot(st_slot),
        .fr_vld(ld_done), .fr_slot(ld_done_slot),
        .ready(ld_ready)
    );

    AST_DROP_PAST_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> ($countones(mapped_row) <= int'(dec_older_cnt))); // R6
    AST_DECODE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && (mapped_row & ~({{(SQ_DEPTH-1){1'b0}}, st_vld} << st_slot)) == '0)
        |=> ld_ready[$past(dec_slot)]); // R2
endmodule

// File: tb/store_vec_sched_tb.sv
module store_vec_sched_tb_top;
    localparam int SQ = 32;
    localparam int LQ = 16;

    localparam logic [2:0] OP_VIOL  = 3'd1;
    localparam logic [2:0] OP_DEC   = 3'd2;
    localparam logic [2:0] OP_STORE = 3'd3;
    localparam logic [2:0] OP_DONE  = 3'd4;
    localparam logic [2:0] OP_CLR   = 3'd5;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] pc;
        logic [3:0] slot;
        logic [4:0] young;   // also store column / distance code
        logic [5:0] cnt;
        logic [3:0] chk;
        logic       exp;
    } step_t;

    localparam int NSTEP = 17;
    localparam step_t STEPS [NSTEP] = '{
        '{OP_VIOL,  8'h10, 4'd0, 5'd0,  6'd0, 4'd0, 1'b0},  // R5 train k=0
        '{OP_DEC,   8'h10, 4'd0, 5'd5,  6'd3, 4'd0, 1'b0},  // R2 waits on col 5
        '{OP_DEC,   8'h20, 4'd1, 5'd5,  6'd3, 4'd1, 1'b1},  // R2 untrained PC
        '{OP_STORE, 8'h00, 4'd0, 5'd4,  6'd0, 4'd0, 1'b0},  // R4 other column
        '{OP_STORE, 8'h00, 4'd0, 5'd5,  6'd0, 4'd0, 1'b1},  // R4 releases
        '{OP_VIOL,  8'h30, 4'd0, 5'd2,  6'd0, 4'd1, 1'b1},  // R5 train k=2
        '{OP_DEC,   8'h30, 4'd2, 5'd1,  6'd5, 4'd2, 1'b0},  // R3 wraps to col 31
        '{OP_DEC,   8'h30, 4'd3, 5'd1,  6'd5, 4'd3, 1'b0},  // R10 second load
        '{OP_STORE, 8'h00, 4'd0, 5'd30, 6'd0, 4'd2, 1'b0},  // R3 col 30 no effect
        '{OP_STORE, 8'h00, 4'd0, 5'd31, 6'd0, 4'd3, 1'b1},  // R10 both released
        '{OP_DONE,  8'h00, 4'd3, 5'd0,  6'd0, 4'd3, 1'b0},  // R8 freed
        '{OP_VIOL,  8'h30, 4'd0, 5'd0,  6'd0, 4'd2, 1'b1},  // R5 old row unchanged
        '{OP_DEC,   8'h30, 4'd4, 5'd10, 6'd4, 4'd4, 1'b0},  // R5 cols 10 and 8
        '{OP_STORE, 8'h00, 4'd0, 5'd10, 6'd0, 4'd4, 1'b0},  // R10 younger first
        '{OP_STORE, 8'h00, 4'd0, 5'd8,  6'd0, 4'd4, 1'b1},  // R10 then older
        '{OP_CLR,   8'h00, 4'd0, 5'd0,  6'd0, 4'd4, 1'b1},  // R9 rows untouched
        '{OP_DEC,   8'h30, 4'd5, 5'd10, 6'd4, 4'd5, 1'b1}   // R9 table wiped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_vld = 1'b0;
    logic [31:0] dec_pc = '0;
    logic [3:0]  dec_slot = '0;
    logic [4:0]  dec_young_idx = '0;
    logic [5:0]  dec_older_cnt = '0;
    logic        st_vld = 1'b0;
    logic [4:0]  st_slot = '0;
    logic        viol_vld = 1'b0;
    logic [31:0] viol_pc = '0;
    logic [4:0]  viol_dist = '0;
    logic        ld_done = 1'b0;
    logic [3:0]  ld_done_slot = '0;
    logic        tbl_clear = 1'b0;
    logic [LQ-1:0] ld_ready;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    store_vec_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .dec_vld(dec_vld), .dec_pc(dec_pc), .dec_slot(dec_slot),
        .dec_young_idx(dec_young_idx), .dec_older_cnt(dec_older_cnt),
        .st_vld(st_vld), .st_slot(st_slot),
        .viol_vld(viol_vld), .viol_pc(viol_pc), .viol_dist(viol_dist),
        .ld_done(ld_done), .ld_done_slot(ld_done_slot),
        .tbl_clear(tbl_clear), .ld_ready(ld_ready)
    );

    task automatic check(input string req, input logic [LQ-1:0] act, input logic [LQ-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One edge passes; strobes drop and outputs are sampled at the next falling edge.
    task automatic tick();
        @(negedge clk);
        dec_vld = 1'b0; st_vld = 1'b0; viol_vld = 1'b0; ld_done = 1'b0; tbl_clear = 1'b0;
    endtask

    task automatic do_step(input step_t s);
        case (s.op)
            OP_VIOL:  begin viol_vld = 1'b1; viol_pc = 32'(s.pc); viol_dist = s.young; end
            OP_DEC:   begin dec_vld = 1'b1; dec_pc = 32'(s.pc); dec_slot = s.slot;
                            dec_young_idx = s.young; dec_older_cnt = s.cnt; end
            OP_STORE: begin st_vld = 1'b1; st_slot = s.young; end
            OP_DONE:  begin ld_done = 1'b1; ld_done_slot = s.slot; end
            OP_CLR:   tbl_clear = 1'b1;
            default:  ;
        endcase
        tick();
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", ld_ready, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", ld_ready, '0);

        for (int i = 0; i < NSTEP; i++) begin
            do_step(STEPS[i]);
            check($sformatf("step %0d (R2-R5,R8-R10)", i),
                  LQ'(ld_ready[STEPS[i].chk]), LQ'(STEPS[i].exp));
        end

        // R6: distance code 3 with only 3 older stores is dropped
        do_step('{OP_VIOL, 8'h40, 4'd0, 5'd3, 6'd0, 4'd0, 1'b0});
        do_step('{OP_DEC, 8'h40, 4'd6, 5'd3, 6'd3, 4'd0, 1'b0});
        check("R6 dropped bit", LQ'(ld_ready[6]), LQ'(1));
        // R6: with 4 older stores the bit maps to column 0 and is kept
        do_step('{OP_DEC, 8'h40, 4'd7, 5'd3, 6'd4, 4'd0, 1'b0});
        check("R6 kept bit", LQ'(ld_ready[7]), LQ'(0));
        do_step('{OP_STORE, 8'h00, 4'd0, 5'd0, 6'd0, 4'd0, 1'b0});
        check("R6 col 0 release", LQ'(ld_ready[7]), LQ'(1));

        // R7: the store issues in the cycle the row is written
        do_step('{OP_VIOL, 8'h50, 4'd0, 5'd0, 6'd0, 4'd0, 1'b0});
        dec_vld = 1'b1; dec_pc = 32'h50; dec_slot = 4'd8;
        dec_young_idx = 5'd7; dec_older_cnt = 6'd1;
        st_vld = 1'b1; st_slot = 5'd7;
        tick();
        check("R7 same-cycle mask", LQ'(ld_ready[8]), LQ'(1));
        // R7 control: without the store the same decode waits
        do_step('{OP_DEC, 8'h50, 4'd9, 5'd7, 6'd1, 4'd0, 1'b0});
        check("R7 control", LQ'(ld_ready[9]), LQ'(0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule